// File: doc/BRIEF.md
# Byte-Window Microcode RAM Loader

This block lets a host fill, and read back, the wide instruction RAM of an embedded sequencer through a narrow byte-register port. The host points a word address at a location, then streams bytes into a single data window. The block collects the bytes into a 32-bit word and commits the word to the RAM when its most significant byte arrives. It then moves the word address on to the next location, so a program loads as one continuous stream of bytes.

Reads through the same window return the bytes of the addressed word in the same order, lowest byte first. The word address advances after the fourth read. A small control register enables loading and drives the sequencer's reset, single-step and pause-disable lines.

The register port has four byte registers at 2-bit offsets: 0 is control, 1 is the data window, 2 is the address low byte and 3 is the address high byte. Register reads are registered and appear on `reg_rdata` one cycle after the read strobe. The RAM read port is combinational: `ram_rdata` must reflect `ram_raddr` within the same cycle.

Top module: `ucode_byte_loader`

## Requirements
- R1: After reset, the control bits, the word address, the byte-lane pointer, `ram_we` and `reg_rdata` are all zero.
- R2: With loading enabled, four successive window writes produce exactly one single-cycle `ram_we` pulse in the cycle after the fourth write. The first byte lands in `ram_wdata[7:0]` and the fourth in `ram_wdata[31:24]`, at the word address that was current while they were written.
- R3: The word address stays unchanged after the first, second and third byte of a word, and reads back one higher after the fourth.
- R4: The address low register (offset 2) holds word-address bits 7:0. Only bit 0 of the address high register (offset 3) is used, as word-address bit 8. Its bits 7:1 are ignored on write and read back as zero.
- R5: A write to either address register returns the byte-lane pointer to lane 0, so bytes written before it are never merged into the next committed word.
- R6: While the load-enable bit (control bit 0) is clear, window writes are ignored. They cause no `ram_we`, do not move the lane pointer and do not change the word address.
- R7: Control bit 1 drives `seq_rst`, bit 2 drives `seq_step` and bit 6 drives `seq_pause_dis`. The control register reads back these three bits and bit 0, with every other bit reading zero.
- R8: A window read returns the byte of the current RAM word selected by the lane pointer. After the fourth read the lane pointer returns to 0 and the word address advances by one.
- R9: The word address wraps from 511 to 0 after the fourth byte of the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register offset: 0 control, 1 window, 2 address low, 3 address high |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_rdata | output | 8 | Registered read data, valid the cycle after `reg_re` |
| ram_raddr | output | ADDR_W | Current word address, used as the RAM read address |
| ram_rdata | input | DATA_W | RAM word at `ram_raddr` |
| ram_we | output | 1 | RAM write enable, one cycle per committed word |
| ram_waddr | output | ADDR_W | RAM write word address |
| ram_wdata | output | DATA_W | RAM write data |
| seq_rst | output | 1 | Sequencer reset control |
| seq_step | output | 1 | Sequencer single-step control |
| seq_pause_dis | output | 1 | Sequencer pause-disable control |

## Verification
The bench builds the block with its default parameters: a 9-bit word address and a 32-bit word, giving four byte lanes. With these values the top word, 511, is only two register writes away, so the address wrap and the single used bit of the high register can be reached directly. Every lane position, including the commit lane, is covered within a handful of cycles per scenario. The bench models the RAM with a combinational read, which lets the window-read results be predicted from bench-owned contents.

// File: rtl/ucl_pkg.sv
package ucl_pkg;
  typedef enum logic [1:0] {
    RG_CTRL = 2'd0,
    RG_WIN  = 2'd1,
    RG_ALO  = 2'd2,
    RG_AHI  = 2'd3
  } ucl_reg_e;

  localparam int CB_LOAD = 0;
  localparam int CB_RST  = 1;
  localparam int CB_STEP = 2;
  localparam int CB_PDIS = 6;
endpackage

// File: rtl/ucl_addr_ctr.sv
module ucl_addr_ctr #(
  parameter int ADDR_W = 9,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [7:0]        wdata,
  input  logic              step,
  output logic [ADDR_W-1:0] word_addr,
  output logic [LANE_W-1:0] lane
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [LANE_W-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_addr <= '0;
      lane      <= '0;
    end else if (lo_we) begin
      word_addr[7:0] <= wdata;
      lane           <= '0;
    end else if (hi_we) begin
      word_addr[ADDR_W-1:8] <= wdata[HI_W-1:0];
      lane                  <= '0;
    end else if (step) begin
      lane <= lane + 1'b1;
      if (lane == LAST) word_addr <= word_addr + 1'b1;
    end
  end

  // R5: an address register write leaves the lane pointer at 0
  a_r5_lane_clear: assert property (@(posedge clk) disable iff (rst)
    (lo_we || hi_we) |=> (lane == '0));

  // R3: without an address write, the address either holds or steps by one
  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (!lo_we && !hi_we) |=> (word_addr == $past(word_addr) ||
                            word_addr == ADDR_W'($past(word_addr) + 1'b1)));
endmodule

// File: rtl/ucl_word_asm.sv
module ucl_word_asm #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [LANE_W-1:0] lane,
  input  logic [7:0]        byte_in,
  input  logic [ADDR_W-1:0] word_addr,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic [DATA_W-1:0] ram_wdata
);
  localparam int BYTES = DATA_W / 8;
  localparam logic [LANE_W-1:0] LAST = '1;

  logic [7:0]        held [BYTES-1];
  logic [DATA_W-1:0] word_next;

  for (genvar g = 0; g < BYTES - 1; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)                                held[g] <= '0;
      else if (push && lane == LANE_W'(g))    held[g] <= byte_in;
    end
  end

  always_comb begin
    word_next[DATA_W-1 -: 8] = byte_in;
    for (int i = 0; i < BYTES - 1; i++) word_next[i*8 +: 8] = held[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_we    <= 1'b0;
      ram_waddr <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we <= 1'b0;
      if (push && lane == LAST) begin
        ram_we    <= 1'b1;
        ram_waddr <= word_addr;
        ram_wdata <= word_next;
      end
    end
  end

  // R2: a commit is always a single-cycle pulse
  a_r2_we_pulse: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> !ram_we);
endmodule

// File: rtl/ucode_byte_loader.sv
module ucode_byte_loader #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_we,
  input  logic              reg_re,
  output logic [7:0]        reg_rdata,
  output logic [ADDR_W-1:0] ram_raddr,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              seq_rst,
  output logic              seq_step,
  output logic              seq_pause_dis
);
  import ucl_pkg::*;

  localparam int BYTES  = DATA_W / 8;
  localparam int LANE_W = $clog2(BYTES);
  localparam int HI_W   = ADDR_W - 8;

  logic              load_en;
  logic              win_wr, win_rd, push, step;
  logic [ADDR_W-1:0] word_addr;
  logic [LANE_W-1:0] lane;
  logic [7:0]        rd_next;

  assign win_wr = reg_we && reg_addr == RG_WIN;
  assign win_rd = reg_re && !reg_we && reg_addr == RG_WIN;
  assign push   = win_wr && load_en;
  assign step   = push || win_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_en       <= 1'b0;
      seq_rst       <= 1'b0;
      seq_step      <= 1'b0;
      seq_pause_dis <= 1'b0;
    end else if (reg_we && reg_addr == RG_CTRL) begin
      load_en       <= reg_wdata[CB_LOAD];
      seq_rst       <= reg_wdata[CB_RST];
      seq_step      <= reg_wdata[CB_STEP];
      seq_pause_dis <= reg_wdata[CB_PDIS];
    end
  end

  ucl_addr_ctr #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_addr (
    .clk       (clk),
    .rst       (rst),
    .lo_we     (reg_we && reg_addr == RG_ALO),
    .hi_we     (reg_we && reg_addr == RG_AHI),
    .wdata     (reg_wdata),
    .step      (step),
    .word_addr (word_addr),
    .lane      (lane)
  );

  ucl_word_asm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) i_asm (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .lane      (lane),
    .byte_in   (reg_wdata),
    .word_addr (word_addr),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_wdata (ram_wdata)
  );

  assign ram_raddr = word_addr;

  always_comb begin
    rd_next = '0;
    case (reg_addr)
      RG_CTRL: begin
        rd_next[CB_LOAD] = load_en;
        rd_next[CB_RST]  = seq_rst;
        rd_next[CB_STEP] = seq_step;
        rd_next[CB_PDIS] = seq_pause_dis;
      end
      RG_WIN:  rd_next = ram_rdata[lane*8 +: 8];
      RG_ALO:  rd_next = word_addr[7:0];
      default: rd_next[HI_W-1:0] = word_addr[ADDR_W-1:8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_next;
  end

  // R6: a blocked window write never commits
  a_r6_blocked: assert property (@(posedge clk) disable iff (rst)
    (win_wr && !load_en) |=> !ram_we);

  // R2: a committed word goes to the address current at its last byte
  a_r2_waddr: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_waddr == $past(word_addr)));

  // R7: control writes reach the sequencer lines
  a_r7_ctrl: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == RG_CTRL) |=>
      (seq_rst == $past(reg_wdata[CB_RST]) && seq_pause_dis == $past(reg_wdata[CB_PDIS])));

  // R4: unused high-address bits read as zero
  a_r4_hi_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_re && !reg_we && reg_addr == RG_AHI) |=> (reg_rdata[7:HI_W] == '0));
endmodule

// File: tb/test_ucode_byte_loader.sv
`timescale 1ns/1ps
module test_ucode_byte_loader;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        reg_addr = '0;
  logic [7:0]        reg_wdata = '0;
  logic              reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0]        reg_rdata;
  logic [ADDR_W-1:0] ram_raddr, ram_waddr;
  logic [DATA_W-1:0] ram_rdata, ram_wdata;
  logic              ram_we, seq_rst, seq_step, seq_pause_dis;
  logic [DATA_W-1:0] mem [0:(1<<ADDR_W)-1];
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  ucode_byte_loader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ucode_byte_loader (.*);

  always @(posedge clk) if (ram_we) mem[ram_waddr] <= ram_wdata;
  assign ram_rdata = mem[ram_raddr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_re = 1'b1;
    @(negedge clk); reg_re = 1'b0; d = reg_rdata;
  endtask

  task automatic set_addr(input logic [8:0] a);
    wr(2'd2, a[7:0]); wr(2'd3, {7'd0, a[8]});
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 reg_rdata", reg_rdata, 0);
    chk("R1 ram_we", ram_we, 0);
    chk("R1 seq lines", {seq_rst, seq_step, seq_pause_dis}, 0);
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd2, v); chk("R1 addr lo", v, 0);
  endtask

  task automatic t_ctrl;
    logic [7:0] v;
    wr(2'd0, 8'h47);
    chk("R7 lines", {seq_rst, seq_step, seq_pause_dis}, 3'b111);
    rd(2'd0, v); chk("R7 readback", v, 8'h47);
    wr(2'd0, 8'hB9);
    chk("R7 lines 2", {seq_rst, seq_step, seq_pause_dis}, 3'b000);
    rd(2'd0, v); chk("R7 masked readback", v, 8'h01);
  endtask

  task automatic t_word;
    logic [7:0] v;
    set_addr(9'h005);
    wr(2'd1, 8'h11); chk("R2 no commit b0", ram_we, 0);
    rd(2'd2, v);     chk("R3 addr after b0", v, 8'h05);
    wr(2'd1, 8'h22); wr(2'd1, 8'h33);
    chk("R2 no commit b2", ram_we, 0);
    rd(2'd2, v);     chk("R3 addr after b2", v, 8'h05);
    wr(2'd1, 8'h44);
    chk("R2 commit", ram_we, 1);
    chk("R2 waddr", ram_waddr, 9'h005);
    chk("R2 wdata", ram_wdata, 32'h44332211);
    @(negedge clk); chk("R2 single pulse", ram_we, 0);
    rd(2'd2, v);     chk("R3 addr after b3", v, 8'h06);
  endtask

  task automatic t_hi;
    logic [7:0] v;
    wr(2'd3, 8'hFF);
    rd(2'd3, v); chk("R4 hi readback", v, 8'h01);
    wr(2'd1, 8'h01); wr(2'd1, 8'h02); wr(2'd1, 8'h03); wr(2'd1, 8'h04);
    chk("R4 waddr bit8", ram_waddr, 9'h106);
  endtask

  task automatic t_lane_reset;
    wr(2'd1, 8'hE1); wr(2'd1, 8'hE2);
    wr(2'd2, 8'h20);
    wr(2'd1, 8'hAA); wr(2'd1, 8'hBB); wr(2'd1, 8'hCC); wr(2'd1, 8'hDD);
    chk("R5 lo clears lane", ram_wdata, 32'hDDCCBBAA);
    chk("R5 lo addr", ram_waddr, 9'h120);
    wr(2'd1, 8'hF1);
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h5A); wr(2'd1, 8'h6B); wr(2'd1, 8'h7C); wr(2'd1, 8'h8D);
    chk("R5 hi clears lane", ram_wdata, 32'h8D7C6B5A);
  endtask

  task automatic t_blocked;
    logic [7:0] v;
    set_addr(9'h040);
    wr(2'd1, 8'h10);
    wr(2'd0, 8'h00);
    for (int i = 0; i < 5; i++) begin
      wr(2'd1, 8'h99);
      chk("R6 no commit", ram_we, 0);
    end
    rd(2'd2, v); chk("R6 addr unchanged", v, 8'h40);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h20); wr(2'd1, 8'h30); wr(2'd1, 8'h40);
    chk("R6 lane kept", ram_wdata, 32'h40302010);
    chk("R6 commit", ram_we, 1);
  endtask

  task automatic t_read;
    logic [7:0] v;
    mem[9'h030] = 32'h87654321;
    mem[9'h031] = 32'hCAFEF00D;
    set_addr(9'h030);
    rd(2'd1, v); chk("R8 lane0", v, 8'h21);
    rd(2'd1, v); chk("R8 lane1", v, 8'h43);
    rd(2'd1, v); chk("R8 lane2", v, 8'h65);
    rd(2'd2, v); chk("R8 addr held", v, 8'h30);
    rd(2'd1, v); chk("R8 lane3", v, 8'h87);
    rd(2'd2, v); chk("R8 addr advanced", v, 8'h31);
    rd(2'd1, v); chk("R8 next word lane0", v, 8'h0D);
  endtask

  task automatic t_wrap;
    logic [7:0] v;
    set_addr(9'h1FF);
    wr(2'd1, 8'hA0); wr(2'd1, 8'hA1); wr(2'd1, 8'hA2); wr(2'd1, 8'hA3);
    chk("R9 waddr top", ram_waddr, 9'h1FF);
    rd(2'd2, v); chk("R9 lo wraps", v, 8'h00);
    rd(2'd3, v); chk("R9 hi wraps", v, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl();
    wr(2'd0, 8'h01);
    t_word();
    t_hi();
    t_lane_reset();
    t_blocked();
    t_read();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule